// File: doc/BRIEF.md
# PCI I/O Window Claim Decoder

This block is the configuration-register slice of one PCI function that owns a small I/O window. It keeps a 32-bit I/O base address register, in which only the base field (bits 15:6) is writable. The register reads back with type bits that mark it as an I/O-space BAR. It also keeps a 16-bit subsystem vendor ID that software may write once after reset.

On the I/O side the block looks at each cycle presented on its I/O inputs and raises a claim flag in the same cycle when the access lies wholly inside the 8-byte window. The window starts at the programmed base. A claim is made only when the function is in the full-power state, the command register's I/O enable is set and the device is switched on. Completing the claimed access belongs to logic outside this block.

Configuration accesses use a dword-addressed port with per-byte enables. Reads return data one clock after the read strobe.

Top module: `iobar_decoder`

## Requirements
- R1: After reset, a read of the base register returns 0x0000_0001 and a read of the subsystem ID register returns 0x0000_0000.
- R2: A write to the base register (dword address BAR_WORD) updates bits 15:6 only. Byte enable 0 covers bits 7:6 and byte enable 1 covers bits 15:8. Bits whose byte enable is clear keep their value.
- R3: In every read of the base register, bits 31:16 and 5:1 are 0 and bit 0 is 1, whatever was written.
- R4: The subsystem ID register (dword address SVID_WORD, data bits 15:0, byte enables 1:0) accepts its first write in which byte enable 0 or 1 is set. Only the enabled bytes are written. Writes that enable only bytes 3:2 leave the register unchanged and do not lock it. Bits 31:16 read as 0.
- R5: Once the subsystem ID register has accepted a write, later writes leave it unchanged until the next reset. A reset clears both the value and the lock.
- R6: The power-state input is coded 00 = D0, 01 = D1, 10 = D2, 11 = D3. No cycle is claimed unless the state is D0, io_enable is 1 and dev_enable is 1.
- R7: A cycle can be claimed only if io_addr[15:6] equals the programmed base and io_addr[5:3] is zero.
- R8: io_size is coded 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = reserved. A reserved size is never claimed. Otherwise a cycle is claimed only if io_addr[2:0] plus the byte count is at most 8.
- R9: io_claim is combinational from the current I/O inputs. A new base takes effect from the clock edge that completes the configuration write, and the old base applies until that edge.
- R10: cfg_rdata holds the addressed register value in the cycle after a read strobe. Otherwise, and for unmapped addresses, it holds 0.
- R11: io_claim is 0 whenever io_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | CFG_AW | Dword address of configuration register |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| io_valid | input | 1 | An I/O cycle is presented |
| io_addr | input | ADDR_W | I/O cycle byte address |
| io_size | input | 2 | I/O cycle size code |
| pm_state | input | 2 | Power-management state code |
| io_enable | input | 1 | Command register I/O enable |
| dev_enable | input | 1 | Device switched on |
| io_claim | output | 1 | The cycle is claimed by this function |

## Verification
The embedded properties check on every cycle that:
- a claim never happens outside D0 or without both enables, or with io_valid low;
- any claim has a matching base field, zero gap bits and a non-reserved size;
- the base field holds when it is not written;
- the ID lock is set by a lower-lane write and freezes the ID value;
- the base register's fixed bits read back correctly, and idle read data is zero.

Only the bench's scenarios can show the rest:
- the exact edge of the window, where offset plus size reaches 8;
- the byte-lane masking of writes against computed values;
- the cycle at which a new base begins to apply;
- that a reset reopens the write-once ID.

// File: rtl/iobar_pkg.sv
package iobar_pkg;

  typedef enum logic [1:0] {
    PM_D0 = 2'b00,
    PM_D1 = 2'b01,
    PM_D2 = 2'b10,
    PM_D3 = 2'b11
  } pm_state_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } io_size_e;

  // Byte count for a size code; zero marks the reserved code.
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE:  size_bytes = 4'd1;
      SZ_WORD:  size_bytes = 4'd2;
      SZ_DWORD: size_bytes = 4'd4;
      default:  size_bytes = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/iobar_base_reg.sv
module iobar_base_reg #(
  parameter int FIELD_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] bit_we,
  input  logic [FIELD_W-1:0] wr_field,
  output logic [FIELD_W-1:0] base_o
);

  logic [FIELD_W-1:0] base_q;

  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            base_q[i] <= 1'b0;
      else if (bit_we[i]) base_q[i] <= wr_field[i];
    end
  end

  assign base_o = base_q;

  // R2: with no bit selected for write, the base holds
  p_base_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_we == '0) |=> $stable(base_q));

endmodule

// File: rtl/iobar_svid_reg.sv
module iobar_svid_reg #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_sel,
  input  logic [ID_W/8-1:0] wr_be,
  input  logic [ID_W-1:0] wr_data,
  output logic [ID_W-1:0] id_o
);

  localparam int LANES = ID_W / 8;

  logic [ID_W-1:0] id_q;
  logic            locked_q;
  logic            wr_hit;

  assign wr_hit = wr_sel && (wr_be != '0) && !locked_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                    id_q[l*8 +: 8] <= 8'h00;
      else if (wr_hit && wr_be[l]) id_q[l*8 +: 8] <= wr_data[l*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         locked_q <= 1'b0;
    else if (wr_hit) locked_q <= 1'b1;
  end

  assign id_o = id_q;

  // R4: a write with any lower lane enabled leaves the register locked
  p_lock_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && (wr_be != '0)) |=> locked_q);

  // R5: once locked, the value and the lock stay put until reset
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> (locked_q && $stable(id_q)));

endmodule

// File: rtl/iobar_claim.sv
module iobar_claim
  import iobar_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BASE_LSB = 6,
  parameter int WIN_LOG2 = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       io_valid_i,
  input  logic [ADDR_W-1:0]          io_addr_i,
  input  logic [1:0]                 io_size_i,
  input  logic [1:0]                 pm_i,
  input  logic                       io_en_i,
  input  logic                       dev_en_i,
  input  logic [ADDR_W-BASE_LSB-1:0] base_i,
  output logic                       claim_o
);

  localparam int SUM_W     = WIN_LOG2 + 4;
  localparam int WIN_BYTES = 1 << WIN_LOG2;

  logic             base_hit;
  logic             gap_zero;
  logic             power_ok;
  logic [3:0]       nbytes;
  logic [SUM_W-1:0] end_off;
  logic             fits;

  assign base_hit = (io_addr_i[ADDR_W-1:BASE_LSB] == base_i);

  if (BASE_LSB > WIN_LOG2) begin : g_gap
    assign gap_zero = (io_addr_i[BASE_LSB-1:WIN_LOG2] == '0);
  end else begin : g_nogap
    assign gap_zero = 1'b1;
  end

  assign power_ok = (pm_state_e'(pm_i) == PM_D0) && io_en_i && dev_en_i;
  assign nbytes   = size_bytes(io_size_i);
  assign end_off  = SUM_W'(io_addr_i[WIN_LOG2-1:0]) + SUM_W'(nbytes);
  assign fits     = (nbytes != 4'd0) && (end_off <= SUM_W'(WIN_BYTES));
  assign claim_o  = io_valid_i && power_ok && base_hit && gap_zero && fits;

  // R6: no claim outside D0 or without both enables
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !((pm_i == 2'b00) && io_en_i && dev_en_i) |-> !claim_o);

  // R7: a claim always falls on the programmed base with clear gap bits
  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    claim_o |-> ((io_addr_i[ADDR_W-1:BASE_LSB] == base_i) &&
                 (io_addr_i[BASE_LSB-1:WIN_LOG2] == '0)));

  // R8: the reserved size code is never claimed
  p_size_r8: assert property (@(posedge clk) disable iff (rst)
    claim_o |-> (io_size_i != 2'b11));

  // R11: nothing is claimed without a valid cycle
  p_valid_r11: assert property (@(posedge clk) disable iff (rst)
    !io_valid_i |-> !claim_o);

endmodule

// File: rtl/iobar_decoder.sv
module iobar_decoder #(
  parameter int CFG_AW    = 6,
  parameter int BAR_WORD  = 8,
  parameter int SVID_WORD = 11,
  parameter int ADDR_W    = 16,
  parameter int BASE_LSB  = 6,
  parameter int WIN_LOG2  = 3,
  parameter int ID_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [1:0]        pm_state,
  input  logic              io_enable,
  input  logic              dev_enable,
  output logic              io_claim
);

  localparam int FIELD_W  = ADDR_W - BASE_LSB;
  localparam int ID_LANES = ID_W / 8;

  logic               sel_bar;
  logic               sel_svid;
  logic [FIELD_W-1:0] bit_we;
  logic [FIELD_W-1:0] base;
  logic [ID_W-1:0]    svid;
  logic [31:0]        bar_word;
  logic [31:0]        svid_word;
  logic               unused_cfg;

  assign sel_bar  = (cfg_addr == CFG_AW'(BAR_WORD));
  assign sel_svid = (cfg_addr == CFG_AW'(SVID_WORD));

  // Per-bit write enables of the base field, taken from its byte lane
  for (genvar i = 0; i < FIELD_W; i++) begin : g_bwe
    assign bit_we[i] = cfg_we && sel_bar && cfg_be[(i + BASE_LSB) / 8];
  end

  iobar_base_reg #(.FIELD_W(FIELD_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .bit_we   (bit_we),
    .wr_field (cfg_wdata[ADDR_W-1:BASE_LSB]),
    .base_o   (base)
  );

  iobar_svid_reg #(.ID_W(ID_W)) u_svid (
    .clk     (clk),
    .rst     (rst),
    .wr_sel  (cfg_we && sel_svid),
    .wr_be   (cfg_be[ID_LANES-1:0]),
    .wr_data (cfg_wdata[ID_W-1:0]),
    .id_o    (svid)
  );

  iobar_claim #(
    .ADDR_W   (ADDR_W),
    .BASE_LSB (BASE_LSB),
    .WIN_LOG2 (WIN_LOG2)
  ) u_claim (
    .clk        (clk),
    .rst        (rst),
    .io_valid_i (io_valid),
    .io_addr_i  (io_addr),
    .io_size_i  (io_size),
    .pm_i       (pm_state),
    .io_en_i    (io_enable),
    .dev_en_i   (dev_enable),
    .base_i     (base),
    .claim_o    (io_claim)
  );

  // Read-back words: fixed type bits around the writable base field
  always_comb begin
    bar_word                    = '0;
    bar_word[ADDR_W-1:BASE_LSB] = base;
    bar_word[0]                 = 1'b1;
    svid_word                   = '0;
    svid_word[ID_W-1:0]         = svid;
  end

  always_ff @(posedge clk) begin
    if (rst)                  cfg_rdata <= '0;
    else if (cfg_rd && sel_bar)  cfg_rdata <= bar_word;
    else if (cfg_rd && sel_svid) cfg_rdata <= svid_word;
    else                         cfg_rdata <= '0;
  end

  assign unused_cfg = ^{cfg_wdata[31:ADDR_W], cfg_wdata[BASE_LSB-1:ID_W-ID_W],
                        cfg_be[3:ID_LANES]};

  // R3: fixed bits of the base register read back correctly
  p_bar_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && sel_bar) |=> ((cfg_rdata[31:16] == 16'h0) &&
                             (cfg_rdata[5:0] == 6'b000001)));

  // R10: read data is zero in a cycle not following a read strobe
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd |=> (cfg_rdata == 32'h0));

endmodule

// File: tb/iobar_decoder_test.sv
`timescale 1ns/1ps
module iobar_decoder_test;

  localparam int BAR_W  = 8;
  localparam int SVID_W = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [1:0]  pm_state = '0;
  logic        io_enable = 1'b0, dev_enable = 1'b0;
  logic        io_claim;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iobar_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .io_valid(io_valid), .io_addr(io_addr),
    .io_size(io_size), .pm_state(pm_state), .io_enable(io_enable),
    .dev_enable(dev_enable), .io_claim(io_claim)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_write(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = 6'(a);
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  // Expected claim, from window arithmetic
  function automatic bit exp_claim(input int base, input int a, input int sz,
                                   input int pm, input bit ioe, input bit dev,
                                   input bit vld);
    int start;
    int nb;
    start = base * 64;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    return vld && (pm == 0) && ioe && dev && (nb != 0) &&
           (a >= start) && (a + nb <= start + 8);
  endfunction

  task automatic drive_io(input int a, input int sz, input int pm,
                          input bit ioe, input bit dev, input bit vld);
    io_addr = 16'(a); io_size = 2'(sz); pm_state = 2'(pm);
    io_enable = ioe; dev_enable = dev; io_valid = vld;
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] model;
    int base;

    do_reset();

    // R1 reset values
    cfg_read(BAR_W, rd);
    chk(rd == 32'h1, "R1 bar reset", rd, 32'h1);
    cfg_read(SVID_W, rd);
    chk(rd == 32'h0, "R1 svid reset", rd, 32'h0);

    // R10 idle and unmapped reads
    @(negedge clk);
    chk(cfg_rdata == 32'h0, "R10 idle rdata", cfg_rdata, 32'h0);
    cfg_read(3, rd);
    chk(rd == 32'h0, "R10 unmapped read", rd, 32'h0);

    // R2 R3 byte-lane sweep of the base register
    model = 16'h0;
    for (int be = 0; be < 16; be++) begin
      logic [31:0] d;
      logic [15:0] m;
      d = 32'hFFFF_FFFF ^ (32'(be) * 32'h1357_9BDF);
      m = (be[0] ? 16'h00C0 : 16'h0) | (be[1] ? 16'hFF00 : 16'h0);
      cfg_write(BAR_W, 4'(be), d);
      model = (model & ~m) | (d[15:0] & m);
      cfg_read(BAR_W, rd);
      chk(rd == (32'h1 | {16'h0, model & 16'hFFC0}), "R2 R3 bar write mask",
          rd, 32'h1 | {16'h0, model & 16'hFFC0});
    end
    cfg_write(BAR_W, 4'hF, 32'hFFFF_FFFF);
    cfg_read(BAR_W, rd);
    chk(rd == 32'h0000_FFC1, "R3 bar all ones", rd, 32'h0000_FFC1);

    // R4 upper-lane-only write neither writes nor locks
    cfg_write(SVID_W, 4'hC, 32'h1234_5678);
    cfg_read(SVID_W, rd);
    chk(rd == 32'h0, "R4 svid upper lanes ignored", rd, 32'h0);
    cfg_write(SVID_W, 4'h1, 32'hFFFF_ABCD);
    cfg_read(SVID_W, rd);
    chk(rd == 32'h0000_00CD, "R4 svid first write", rd, 32'h0000_00CD);
    // R5 locked
    cfg_write(SVID_W, 4'hF, 32'hFFFF_FFFF);
    cfg_read(SVID_W, rd);
    chk(rd == 32'h0000_00CD, "R5 svid locked", rd, 32'h0000_00CD);

    // R6 R7 R8 window sweep around a chosen base
    base = 10'h2A5;
    cfg_write(BAR_W, 4'h3, 32'(base) << 6);
    for (int off = 0; off < 128; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        int a;
        bit e;
        a = (base * 64 + off - 32) & 16'hFFFF;
        drive_io(a, sz, 0, 1'b1, 1'b1, 1'b1);
        e = exp_claim(base, a, sz, 0, 1'b1, 1'b1, 1'b1);
        chk(io_claim == e, "R7 R8 window sweep", 32'(io_claim), 32'(e));
      end
    end

    // R6 R11 gating combinations
    for (int c = 0; c < 32; c++) begin
      bit e;
      drive_io(base * 64 + 2, 1, c & 3, c[2], c[3], c[4]);
      e = exp_claim(base, base * 64 + 2, 1, c & 3, c[2], c[3], c[4]);
      chk(io_claim == e, "R6 R11 gating", 32'(io_claim), 32'(e));
    end

    // R9 base update timing
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(BAR_W); cfg_be = 4'h3;
    cfg_wdata = 32'h0000_0040;
    drive_io(64, 0, 0, 1'b1, 1'b1, 1'b1);
    chk(io_claim == 1'b0, "R9 old base before edge", 32'(io_claim), 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
    #1;
    chk(io_claim == 1'b1, "R9 new base after edge", 32'(io_claim), 32'd1);

    // R7 R8 sweep over all base values
    for (int b = 0; b < 1024; b++) begin
      cfg_write(BAR_W, 4'h3, 32'(b) << 6);
      drive_io(b * 64 + 4, 2, 0, 1'b1, 1'b1, 1'b1);
      chk(io_claim == 1'b1, "R8 dword at window end", 32'(io_claim), 32'd1);
      drive_io(b * 64 + 5, 2, 0, 1'b1, 1'b1, 1'b1);
      chk(io_claim == 1'b0, "R8 dword past window end", 32'(io_claim), 32'd0);
      drive_io(((b + 1) & 1023) * 64, 0, 0, 1'b1, 1'b1, 1'b1);
      chk(io_claim == 1'b0, "R7 next base rejected", 32'(io_claim), 32'd0);
    end

    // R1 R5 reset reopens the ID and clears the base
    do_reset();
    cfg_read(BAR_W, rd);
    chk(rd == 32'h1, "R1 bar after second reset", rd, 32'h1);
    cfg_read(SVID_W, rd);
    chk(rd == 32'h0, "R5 svid cleared by reset", rd, 32'h0);
    cfg_write(SVID_W, 4'h3, 32'h0000_5A5A);
    cfg_read(SVID_W, rd);
    chk(rd == 32'h0000_5A5A, "R5 svid rewritable after reset", rd, 32'h0000_5A5A);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule